// File: doc/BRIEF.md
# Scan-Table Module Assignment Engine

This block is the second half of the parameter assignment stage in a shared-memory switch built on a sliding window of memory slots. Each packet reaches it with a slot row `j` and a round `k` already chosen upstream. The block picks the memory module `i` that will hold the packet and records `k` in a scan table indexed by row and module. A zero entry in that table means the entry is empty.

Modules already handed out in the current switch cycle are kept in a mask, and the primary search skips them. If that search finds nothing, a fallback search over the table row alone picks a module that another packet of the same cycle is also using, and the block flags the result as a duplicate.

The block also reports the number of empty entries in a look-ahead row, which the upstream drop logic uses. This count is reduced by one when the packet being written in the same cycle goes to that same row. On every sliding-window update strobe the block:
- clears the table entries that have expired,
- empties the mask,
- advances its own window counter.

Top module: `slot_assign`

## Requirements
- R1: After reset `outValid`, `outModule` and `outDup` are 0, every table entry is empty, so `peekFree` equals MODS for any row, and the window counter stands at row 1, round 1.
- R2: A packet presented with `pktValid` is answered one clock later with `outValid`=1. `outRow`, `outRound` and `outDest` carry the packet's inputs. `outModule` is the lowest-numbered column that is empty in row `pktRow` and unused in this switch cycle, encoded as column index + 1 (1..MODS).
- R3: A module assigned earlier in the same switch cycle, for any row, is excluded from the primary search.
- R4: If the primary search fails but row `pktRow` has an empty entry, `outModule` is the lowest empty column + 1 and `outDup` is 1.
- R5: If row `pktRow` has no empty entry, `outModule` is 0 and `outDup` is 0, and the table is left unchanged.
- R6: `peekFree` is combinational and equals the number of empty entries in row `peekRow`.
- R7: While `pktValid` is high and `peekRow` equals `pktRow`, `peekFree` is one lower than the count in R6, and never lower than 0.
- R8: On `swUpdate`, every entry of the counter's current row whose stored round equals the counter's current round is emptied. All other entries keep their values.
- R9: Each `swUpdate` advances the counter row through 1..ROWS. The round advances through 1..ROUNDS only when the row wraps back to 1.
- R10: `swUpdate` empties the used-module mask, so the next switch cycle may reuse every module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | Packet present this cycle |
| pktRow | input | RW | Slot row j of the packet (1..ROWS) |
| pktRound | input | KW | Round k of the packet (1..ROUNDS) |
| pktDest | input | DEST_W | Destination port, passed through |
| peekRow | input | RW | Look-ahead row for the empty count |
| swUpdate | input | 1 | Sliding-window update / end of switch cycle |
| outValid | output | 1 | Assignment result valid |
| outModule | output | IW | Assigned module i (1..MODS), 0 when none |
| outRow | output | RW | Passed-through row |
| outRound | output | KW | Passed-through round |
| outDest | output | DEST_W | Passed-through destination |
| outDup | output | 1 | Module shared with an earlier packet this cycle |
| peekFree | output | IW | Empty entries in the look-ahead row |

## Verification
The hardest states to reach are the duplicate fallback and the expiry of particular entries. The duplicate case needs a switch cycle in which every module bit is already used while the target row still has room. The stimulus reaches it by filling one row completely within a single switch cycle, which also sets every mask bit, and then sending a packet to an empty row.

Expiry depends on the internal window counter. The bench therefore steps the counter with a known number of updates and watches the empty counts of rows that hold a mix of rounds. It also carries the counter through a row wrap to show that the round has advanced.

// File: rtl/slot_pkg.sv
package slot_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic write;      // packet to be assigned and recorded
    logic sweep;      // expire entries of the current window row
    logic maskReset;  // start of a new switch cycle
  } slot_ctl_t;
endpackage

// File: rtl/slot_ctrl.sv
module slot_ctrl #(
  parameter int ROWS   = 12,
  parameter int ROUNDS = 2,
  localparam int RW = $clog2(ROWS + 1),
  localparam int KW = $clog2(ROUNDS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pktValid,
  input  logic                swUpdate,
  output slot_pkg::slot_ctl_t ctl,
  output logic [RW-1:0]       swRow,
  output logic [KW-1:0]       swRound
);
  always_comb begin
    ctl.write     = pktValid;
    ctl.sweep     = swUpdate;
    ctl.maskReset = swUpdate;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swRow   <= RW'(1);
      swRound <= KW'(1);
    end else if (swUpdate) begin
      if (swRow == RW'(ROWS)) begin
        swRow   <= RW'(1);
        swRound <= (swRound == KW'(ROUNDS)) ? KW'(1) : swRound + KW'(1);
      end else begin
        swRow <= swRow + RW'(1);
      end
    end
  end

  // R9: counter row stays within 1..ROWS
  a_r9_row_range: assert property (@(posedge clk) disable iff (!rst_n)
    (swRow >= RW'(1)) && (swRow <= RW'(ROWS)));

  // R9: row wrap brings the row back to 1 and moves the round
  a_r9_wrap_advances_round: assert property (@(posedge clk) disable iff (!rst_n)
    (swUpdate && swRow == RW'(ROWS)) |=> (swRow == RW'(1)) &&
      ((ROUNDS == 1) || (swRound != $past(swRound))));

  // R9: round holds while the row does not wrap
  a_r9_round_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(swUpdate && swRow == RW'(ROWS)) |=> $stable(swRound));
endmodule

// File: rtl/slot_dpath.sv
module slot_dpath #(
  parameter int ROWS   = 12,
  parameter int MODS   = 8,
  parameter int ROUNDS = 2,
  parameter int DEST_W = 3,
  localparam int RW    = $clog2(ROWS + 1),
  localparam int KW    = $clog2(ROUNDS + 1),
  localparam int IW    = $clog2(MODS + 1),
  localparam int CW    = $clog2(MODS),
  localparam int RAW   = $clog2(ROWS),
  localparam int DEPTH = (1 << RAW) * MODS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  slot_pkg::slot_ctl_t ctl,
  input  logic [RW-1:0]       swRow,
  input  logic [KW-1:0]       swRound,
  input  logic [RW-1:0]       pktRow,
  input  logic [KW-1:0]       pktRound,
  input  logic [DEST_W-1:0]   pktDest,
  input  logic [RW-1:0]       peekRow,
  output logic                outValid,
  output logic [IW-1:0]       outModule,
  output logic [RW-1:0]       outRow,
  output logic [KW-1:0]       outRound,
  output logic [DEST_W-1:0]   outDest,
  output logic                outDup,
  output logic [IW-1:0]       peekFree
);
  logic [KW-1:0]  scanMem [DEPTH];
  logic [MODS-1:0] usedMask;
  logic [MODS-1:0] rowUsed;
  logic [RAW-1:0]  wrRowAddr, peekRowAddr, sweepRowAddr;
  logic [IW-1:0]   pick1, pick2, chosen, emptyCnt;
  logic [CW-1:0]   chosenCol;
  logic            dupUse;

  assign wrRowAddr    = RAW'(pktRow - RW'(1));
  assign peekRowAddr  = RAW'(peekRow - RW'(1));
  assign sweepRowAddr = RAW'(swRow - RW'(1));

  always_comb begin
    for (int c = 0; c < MODS; c++)
      rowUsed[c] = (scanMem[{wrRowAddr, CW'(c)}] != '0);
  end

  // primary search: row occupancy OR this cycle's mask; lowest column wins
  always_comb begin
    pick1 = '0;
    for (int c = MODS - 1; c >= 0; c--)
      if (!(rowUsed[c] || usedMask[c])) pick1 = IW'(c + 1);
  end

  // fallback search: row occupancy only
  always_comb begin
    pick2 = '0;
    for (int c = MODS - 1; c >= 0; c--)
      if (!rowUsed[c]) pick2 = IW'(c + 1);
  end

  assign dupUse    = (pick1 == '0) && (pick2 != '0);
  assign chosen    = (pick1 != '0) ? pick1 : pick2;
  assign chosenCol = CW'(chosen - IW'(1));

  // empty count of the look-ahead row, speculating on the packet in flight
  always_comb begin
    emptyCnt = '0;
    for (int c = 0; c < MODS; c++)
      emptyCnt = emptyCnt + IW'(scanMem[{peekRowAddr, CW'(c)}] == '0);
  end
  assign peekFree = (ctl.write && peekRow == pktRow && emptyCnt != '0)
                    ? emptyCnt - IW'(1) : emptyCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) scanMem[a] <= '0;
      usedMask  <= '0;
      outValid  <= 1'b0;
      outModule <= '0;
      outRow    <= '0;
      outRound  <= '0;
      outDest   <= '0;
      outDup    <= 1'b0;
    end else begin
      if (ctl.sweep)
        for (int c = 0; c < MODS; c++)
          if (scanMem[{sweepRowAddr, CW'(c)}] == swRound)
            scanMem[{sweepRowAddr, CW'(c)}] <= '0;
      if (ctl.write && chosen != '0)
        scanMem[{wrRowAddr, chosenCol}] <= pktRound;
      if (ctl.maskReset)
        usedMask <= '0;
      else if (ctl.write && chosen != '0)
        usedMask[chosenCol] <= 1'b1;
      outValid  <= ctl.write;
      outModule <= ctl.write ? chosen : '0;
      outDup    <= ctl.write && dupUse;
      outRow    <= pktRow;
      outRound  <= pktRound;
      outDest   <= pktDest;
    end
  end

  // R2: a result follows every accepted packet by one cycle
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.write |=> outValid);

  // R4: duplicate flag only with a real module
  a_r4_dup_has_module: assert property (@(posedge clk) disable iff (!rst_n)
    outDup |-> (outValid && outModule != '0));

  // R10: mask is empty after an update
  a_r10_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.maskReset |=> (usedMask == '0));

  // R6: empty count never exceeds the row width
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    peekFree <= IW'(MODS));

  // R3: a fresh (non-duplicate) module was not used earlier this cycle
  a_r3_fresh_module: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.write && !ctl.maskReset && pick1 != '0) |=>
      $countones(usedMask) == $countones($past(usedMask)) + 1);
endmodule

// File: rtl/slot_assign.sv
module slot_assign #(
  parameter int ROWS   = 12,
  parameter int MODS   = 8,
  parameter int ROUNDS = 2,
  parameter int DEST_W = 3,
  localparam int RW = $clog2(ROWS + 1),
  localparam int KW = $clog2(ROUNDS + 1),
  localparam int IW = $clog2(MODS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pktValid,
  input  logic [RW-1:0]     pktRow,
  input  logic [KW-1:0]     pktRound,
  input  logic [DEST_W-1:0] pktDest,
  input  logic [RW-1:0]     peekRow,
  input  logic              swUpdate,
  output logic              outValid,
  output logic [IW-1:0]     outModule,
  output logic [RW-1:0]     outRow,
  output logic [KW-1:0]     outRound,
  output logic [DEST_W-1:0] outDest,
  output logic              outDup,
  output logic [IW-1:0]     peekFree
);
  slot_pkg::slot_ctl_t ctl;
  logic [RW-1:0] swRow;
  logic [KW-1:0] swRound;

  slot_ctrl #(.ROWS(ROWS), .ROUNDS(ROUNDS)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .pktValid(pktValid), .swUpdate(swUpdate),
    .ctl(ctl), .swRow(swRow), .swRound(swRound));

  slot_dpath #(.ROWS(ROWS), .MODS(MODS), .ROUNDS(ROUNDS), .DEST_W(DEST_W)) i_dpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .swRow(swRow), .swRound(swRound),
    .pktRow(pktRow), .pktRound(pktRound), .pktDest(pktDest), .peekRow(peekRow),
    .outValid(outValid), .outModule(outModule), .outRow(outRow),
    .outRound(outRound), .outDest(outDest), .outDup(outDup), .peekFree(peekFree));
endmodule

// File: tb/test_slot_assign.sv
module test_slot_assign;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pktValid = 1'b0;
  logic [3:0] pktRow = 4'd1;
  logic [1:0] pktRound = 2'd1;
  logic [2:0] pktDest = 3'd0;
  logic [3:0] peekRow = 4'd1;
  logic swUpdate = 1'b0;
  logic outValid, outDup;
  logic [3:0] outModule, outRow, peekFree;
  logic [1:0] outRound;
  logic [2:0] outDest;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slot_assign i_slot_assign (
    .clk(clk), .rst_n(rst_n), .pktValid(pktValid), .pktRow(pktRow),
    .pktRound(pktRound), .pktDest(pktDest), .peekRow(peekRow),
    .swUpdate(swUpdate), .outValid(outValid), .outModule(outModule),
    .outRow(outRow), .outRound(outRound), .outDest(outDest),
    .outDup(outDup), .peekFree(peekFree));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic peek(input int row, input int exp, input string req);
    pktValid = 1'b0;
    peekRow = 4'(row);
    #1;
    chk(req, int'(peekFree), exp);
  endtask

  // send one packet; optionally check the speculative count before the edge
  task automatic send(input int row, input int rnd, input int dst,
                      input int expMod, input int expDup, input string req,
                      input int specRow = 0, input int specExp = -1);
    pktValid = 1'b1; pktRow = 4'(row); pktRound = 2'(rnd); pktDest = 3'(dst);
    if (specRow != 0) begin
      peekRow = 4'(specRow);
      #1;
      chk("R7 speculative count", int'(peekFree), specExp);
    end
    @(posedge clk); @(negedge clk);
    chk({req, " module"}, int'(outModule), expMod);
    chk({req, " dup"}, int'(outDup), expDup);
    if (!outValid) chk("R2 valid", 0, 1);
    pktValid = 1'b0;
  endtask

  task automatic update(input int n);
    for (int u = 0; u < n; u++) begin
      swUpdate = 1'b1;
      @(posedge clk); @(negedge clk);
      swUpdate = 1'b0;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 outModule", int'(outModule), 0);
    chk("R1 outDup", int'(outDup), 0);
    peek(3, 8, "R1 empty table");
    peek(12, 8, "R1 empty table row 12");
  endtask

  task automatic t_primary;
    send(3, 1, 5, 1, 0, "R2 first packet");
    chk("R2 row passthrough", int'(outRow), 3);
    chk("R2 round passthrough", int'(outRound), 1);
    chk("R2 dest passthrough", int'(outDest), 5);
    send(5, 1, 2, 2, 0, "R3 mask skips module 1");
    send(3, 2, 1, 3, 0, "R3 row and mask both skipped");
    peek(3, 6, "R6 empty count row 3");
    update(1);   // window (1,1) -> (2,1)
    send(5, 2, 0, 1, 0, "R10 mask cleared after update");
  endtask

  task automatic t_spec;
    // row 5 holds modules 1,2; mask holds module 1
    send(5, 2, 0, 3, 0, "R2 row 5 third", 5, 5);
    peek(5, 5, "R6 row 5 after write");
  endtask

  task automatic t_dup_full;
    update(1);   // window (2,1) -> (3,1), mask empty
    for (int m = 1; m <= 8; m++) send(8, 1, 0, m, 0, "R2 fill row 8");
    send(9, 1, 0, 1, 1, "R4 fallback duplicate");
    send(8, 2, 0, 0, 0, "R5 full row", 8, 0);
    peek(8, 0, "R5 row 8 unchanged");
  endtask

  task automatic t_sweep;
    update(5);   // sweeps rows 3..7 round 1
    peek(3, 7, "R8 row 3 keeps round 2");
    peek(5, 6, "R8 row 5 keeps round 2");
    update(1);   // sweeps row 8 round 1
    peek(8, 8, "R8 row 8 emptied");
    peek(9, 7, "R8 row 9 untouched");
  endtask

  task automatic t_wrap;
    update(1);   // sweeps row 9 round 1 -> (10,1)
    peek(9, 8, "R8 row 9 emptied");
    send(1, 2, 0, 1, 0, "R2 row 1 round 2");
    send(1, 1, 0, 2, 0, "R2 row 1 round 1");
    update(3);   // rows 10..12 round 1 -> (1,2)
    peek(1, 6, "R9 row 1 still full before wrap sweep");
    update(1);   // sweeps row 1 round 2
    peek(1, 7, "R9 round advanced at wrap");
    update(2);   // rows 2,3 round 2
    peek(3, 8, "R9 round 2 sweep of row 3");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_primary();
    t_spec();
    t_dup_full();
    t_sweep();
    t_wrap();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule